// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block produces a single pulse-width-modulated output from a 16-bit up-counter. A prescaler feeds the counter with count ticks. Each period lasts a programmed number of ticks. The output flip-flop is low at the start of each period and goes high for the last W ticks of the period, where W is the programmed pulse width. When the pulse width is zero the output stays low. When the pulse width reaches or passes the period it stays high. The pin shows either the flip-flop or its inverse, as a polarity bit selects.

Software writes the period and pulse-width values through plain write strobes. With the glitch-free mode on, a written value waits in a shadow register and moves into the active compare set only at the next period start. With the mode off, the compare logic uses a written value from the cycle after the write. A sticky flag is set at every period start. It tells software that a new shadow pair may be written. The interrupt request is that flag gated by an enable input.

The block has no streaming data path, so every pin is a plain control or status signal with no handshake. The control fields are captured together on `ctl_wr`.

Top module: `pwm_dbuf_top`

## Requirements
- R1: After reset, `pwm_out`, `out_level`, `flag` and `irq` are all 0, and the captured control fields are all 0.
- R2: While the captured enable is 0, the counter is held at zero and the flip-flop is low one cycle later, so `out_level` is 0 and `pwm_out` equals the captured polarity. The first count tick after enable starts a new period with the count at 0.
- R3: With a period value P (0 acts as 1) and a pulse width W where 0 < W < P, the count c runs 0..P-1 on successive ticks. After the tick that sets the count to c, `out_level` is 1 exactly when c >= P-W.
- R4: With W = 0, `out_level` stays 0 for the whole period. With W >= P and W != 0, it stays 1 for the whole period.
- R5: `out_level` is the flip-flop state. `pwm_out` equals that state when `ctl_pol`=0 and its inverse when `ctl_pol`=1.
- R6: `flag` becomes 1 after every period start, which is the first tick after enable and each wrap of the count. It then stays 1 until it is cleared.
- R7: A 1 on `flag_clr` clears `flag` at the next clock edge. If a period start happens at the same edge, `flag` stays 1.
- R8: `irq` is 1 exactly when `flag` is 1 and `irq_en` is 1.
- R9: With `ctl_gfree`=1, written period and pulse-width values have no effect on the output until the next period start. They apply from that period onward.
- R10: With `ctl_gfree`=0, a value written at a clock edge is used by the compare logic from the following edge onward, within the running period.
- R11: With `ctl_div`=0 a count tick occurs every clock. With `ctl_div`=1 a tick occurs once every 256 clocks, and the first period start comes 256 clocks after the enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Captures the four control fields |
| ctl_en | input | 1 | Enable value to capture |
| ctl_pol | input | 1 | Polarity value to capture (1 = invert pin) |
| ctl_div | input | 1 | Tick rate value to capture (0 = every clock, 1 = every 256 clocks) |
| ctl_gfree | input | 1 | Glitch-free (buffered) mode value to capture |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | 16 | Period value in ticks |
| pw_wr | input | 1 | Pulse-width write strobe |
| pw_wdata | input | 16 | Pulse width in ticks |
| flag_clr | input | 1 | Clear request for the period-start flag |
| irq_en | input | 1 | Interrupt enable |
| pwm_out | output | 1 | Output pin after polarity |
| out_level | output | 1 | Flip-flop state before polarity |
| flag | output | 1 | Sticky period-start flag |
| irq | output | 1 | Interrupt request |

## Verification
The waveform is tried with several duty settings: a mid-range duty at both polarities, a single-tick pulse, zero width, width equal to the period and width above the period. These separate the compare threshold from the two saturated cases, and they show the polarity stage acting apart from the status level. The same mid-period write of a new period and width is made with buffering on and with it off. The output must keep the old pattern to the boundary in the first case and change inside the period in the second. The flag is tested by clearing it between starts, by holding a clear across back-to-back one-tick periods, and by enabling at the slow tick rate, where its timing shows the 256-clock spacing.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    DIV_ONE  = 1'b0,
    DIV_SLOW = 1'b1
  } div_sel_e;

  typedef struct packed {
    logic     en;
    logic     pol;
    div_sel_e div;
    logic     gfree;
  } ctl_t;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic tick
);
  generate
    if (DIV > 1) begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pc;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pc <= '0;
        end else if (!run || !slow || pc == LAST) begin
          pc <= '0;
        end else begin
          pc <= pc + 1'b1;
        end
      end

      assign tick = run && (!slow || pc == LAST);
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate
endmodule

// File: rtl/pwm_cmp_regs.sv
module pwm_cmp_regs #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          per_wr,
  input  logic [CW-1:0] per_wdata,
  input  logic          pw_wr,
  input  logic [CW-1:0] pw_wdata,
  input  logic          gfree,
  input  logic          load,
  output logic [CW-1:0] sh_per,
  output logic [CW-1:0] sh_pw,
  output logic [CW-1:0] cur_per,
  output logic [CW-1:0] cur_pw
);
  logic [CW-1:0] act_per, act_pw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_per <= '0;
      sh_pw  <= '0;
    end else begin
      if (per_wr) sh_per <= per_wdata;
      if (pw_wr)  sh_pw  <= pw_wdata;
    end
  end

  // active pair moves only at a period start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_per <= '0;
      act_pw  <= '0;
    end else if (load) begin
      act_per <= sh_per;
      act_pw  <= sh_pw;
    end
  end

  assign cur_per = gfree ? act_per : sh_per;
  assign cur_pw  = gfree ? act_pw  : sh_pw;
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] sh_per,
  input  logic [CW-1:0] sh_pw,
  input  logic [CW-1:0] cur_per,
  input  logic [CW-1:0] cur_pw,
  output logic          start,
  output logic [CW-1:0] cnt,
  output logic          ff
);
  logic          pend;
  logic [CW:0]   cnt_p1;
  logic          wrap;
  logic [CW-1:0] cnt_nx, use_per, use_pw, low_span;
  logic          hi;

  always_comb begin
    cnt_p1   = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    wrap     = pend || (cnt_p1 >= {1'b0, cur_per});
    start    = run && tick && wrap;
    cnt_nx   = start ? '0 : cnt_p1[CW-1:0];
    use_per  = start ? sh_per : cur_per;
    use_pw   = start ? sh_pw  : cur_pw;
    low_span = use_per - use_pw;
    hi       = (use_pw != '0) && ((use_pw >= use_per) || (cnt_nx >= low_span));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ff   <= 1'b0;
      pend <= 1'b1;
    end else if (!run) begin
      cnt  <= '0;
      ff   <= 1'b0;
      pend <= 1'b1;
    end else if (tick) begin
      cnt  <= cnt_nx;
      ff   <= hi;
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_flag.sv
module pwm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_p,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set_p) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  assign irq = flag && irq_en;
endmodule

// File: rtl/pwm_dbuf_top.sv
module pwm_dbuf_top
  import pwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DIV = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          ctl_en,
  input  logic          ctl_pol,
  input  logic          ctl_div,
  input  logic          ctl_gfree,
  input  logic          per_wr,
  input  logic [CW-1:0] per_wdata,
  input  logic          pw_wr,
  input  logic [CW-1:0] pw_wdata,
  input  logic          flag_clr,
  input  logic          irq_en,
  output logic          pwm_out,
  output logic          out_level,
  output logic          flag,
  output logic          irq
);
  ctl_t          ctl_q;
  logic          run, slow, tick, start, ff;
  logic [CW-1:0] cnt, sh_per, sh_pw, cur_per, cur_pw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q.en    <= ctl_en;
      ctl_q.pol   <= ctl_pol;
      ctl_q.div   <= div_sel_e'(ctl_div);
      ctl_q.gfree <= ctl_gfree;
    end
  end

  assign run  = ctl_q.en;
  assign slow = (ctl_q.div == DIV_SLOW);

  pwm_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .slow(slow), .tick(tick)
  );

  pwm_cmp_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .per_wr(per_wr), .per_wdata(per_wdata),
    .pw_wr(pw_wr), .pw_wdata(pw_wdata),
    .gfree(ctl_q.gfree), .load(start),
    .sh_per(sh_per), .sh_pw(sh_pw), .cur_per(cur_per), .cur_pw(cur_pw)
  );

  pwm_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .sh_per(sh_per), .sh_pw(sh_pw), .cur_per(cur_per), .cur_pw(cur_pw),
    .start(start), .cnt(cnt), .ff(ff)
  );

  pwm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_p(start), .clr(flag_clr),
    .irq_en(irq_en), .flag(flag), .irq(irq)
  );

  assign out_level = ff;
  assign pwm_out   = ff ^ ctl_q.pol;
endmodule

// File: rtl/pwm_chk.sv
module pwm_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          slow,
  input logic          tick,
  input logic          start,
  input logic [CW-1:0] cnt,
  input logic          flag_clr,
  input logic          flag,
  input logic          out_level
);
  a_r2_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && !out_level));

  a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0));

  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> flag);

  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !start) |=> !flag);

  a_r11_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (slow && tick) |=> (!tick || !slow));
endmodule

bind pwm_dbuf_top pwm_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .slow(slow), .tick(tick),
  .start(start), .cnt(cnt), .flag_clr(flag_clr), .flag(flag),
  .out_level(out_level)
);

// File: tb/sim_pwm_dbuf_top.sv
`timescale 1ns/1ps
module sim_pwm_dbuf_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, ctl_en = 0, ctl_pol = 0, ctl_div = 0, ctl_gfree = 0;
  logic per_wr = 0, pw_wr = 0, flag_clr = 0, irq_en = 0;
  logic [15:0] per_wdata = '0, pw_wdata = '0;
  logic pwm_out, out_level, flag, irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] exq[$];
  string tagq[$];

  always #2 clk = ~clk;

  pwm_dbuf_top u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_pol(ctl_pol),
    .ctl_div(ctl_div), .ctl_gfree(ctl_gfree), .per_wr(per_wr), .per_wdata(per_wdata),
    .pw_wr(pw_wr), .pw_wdata(pw_wdata), .flag_clr(flag_clr), .irq_en(irq_en),
    .pwm_out(pwm_out), .out_level(out_level), .flag(flag), .irq(irq)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: one expected {level, pin} per cycle
  always @(negedge clk) begin
    if (exq.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exq.pop_front();
      t = tagq.pop_front();
      chk({out_level, pwm_out} == e, t, {out_level, pwm_out}, e);
    end
  end

  function automatic bit lvl(int c, int p, int w);
    if (w == 0) return 0;
    if (w >= p) return 1;
    return c >= (p - w);
  endfunction

  task automatic push1(bit l, bit pol, string t);
    exq.push_back({l, l ^ pol});
    tagq.push_back(t);
  endtask

  task automatic push_period(int p, int w, bit pol, string t);
    for (int c = 0; c < p; c++) push1(lvl(c, p, w), pol, t);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_ctl(bit en, bit pol, bit dv, bit gf);
    ctl_en = en; ctl_pol = pol; ctl_div = dv; ctl_gfree = gf; ctl_wr = 1;
    step();
    ctl_wr = 0;
  endtask

  task automatic enable(bit pol, bit gf);
    ctl_en = 1; ctl_pol = pol; ctl_div = 0; ctl_gfree = gf; ctl_wr = 1;
    @(posedge clk);
    #1;
    ctl_wr = 0;
    push1(0, pol, "R2 enable");
  endtask

  task automatic write_cmp(int p, int w);
    per_wdata = 16'(p); pw_wdata = 16'(w); per_wr = 1; pw_wr = 1;
    step();
    per_wr = 0; pw_wr = 0;
  endtask

  task automatic drain();
    while (exq.size() > 0) step();
    step();
  endtask

  task automatic stop(bit pol);
    write_ctl(0, pol, 0, 0);
    step();
    chk(out_level == 0, "R2 off level", out_level, 0);
    chk(pwm_out == pol, "R2 off pin", pwm_out, pol);
  endtask

  task automatic clr_flag();
    flag_clr = 1;
    step();
    flag_clr = 0;
  endtask

  task automatic run_sc(int p, int w, bit pol, int n, string t);
    write_cmp(p, w);
    enable(pol, 0);
    for (int i = 0; i < n; i++) push_period(p, w, pol, t);
    drain();
    stop(pol);
  endtask

  initial begin
    #(4 * 200000);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk(pwm_out == 0, "R1 pin", pwm_out, 0);
    chk(out_level == 0, "R1 level", out_level, 0);
    chk(flag == 0, "R1 flag", flag, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    rst_n = 1;
    step();

    run_sc(5, 2, 0, 3, "R3 duty 2/5");
    run_sc(5, 2, 1, 2, "R5 inverted");
    run_sc(7, 1, 0, 2, "R3 single tick");
    run_sc(6, 0, 0, 2, "R4 zero width");
    run_sc(4, 4, 0, 2, "R4 width=period");
    run_sc(4, 9, 1, 2, "R4 width>period");

    // R9: buffered write mid-period waits for the boundary
    write_cmp(4, 1);
    enable(0, 1);
    push_period(4, 1, 0, "R9 old");
    push_period(4, 1, 0, "R9 old held");
    push_period(6, 3, 0, "R9 new");
    push_period(6, 3, 0, "R9 new");
    repeat (5) step();
    write_cmp(6, 3);
    drain();
    stop(0);

    // R10: unbuffered write applies inside the running period
    write_cmp(4, 1);
    enable(0, 0);
    push_period(4, 1, 0, "R10 old");
    push1(0, 0, "R10 c0"); push1(0, 0, "R10 c1");
    push1(0, 0, "R10 c2"); push1(1, 0, "R10 c3");
    push1(1, 0, "R10 c4"); push1(1, 0, "R10 c5");
    push_period(6, 3, 0, "R10 new");
    repeat (5) step();
    write_cmp(6, 3);
    drain();
    stop(0);

    // R6 R7 R8 flag behaviour
    clr_flag();
    chk(flag == 0, "R7 clear", flag, 0);
    write_cmp(10, 3);
    irq_en = 0;
    write_ctl(1, 0, 0, 0);
    chk(flag == 0, "R6 before start", flag, 0);
    step();
    chk(flag == 1, "R6 first start", flag, 1);
    chk(irq == 0, "R8 masked", irq, 0);
    irq_en = 1;
    step();
    chk(flag == 1, "R6 sticky", flag, 1);
    chk(irq == 1, "R8 raised", irq, 1);
    clr_flag();
    chk(flag == 0, "R7 cleared", flag, 0);
    chk(irq == 0, "R8 dropped", irq, 0);
    repeat (7) step();
    chk(flag == 0, "R6 no start yet", flag, 0);
    step();
    chk(flag == 1, "R6 wrap start", flag, 1);
    write_cmp(1, 0);
    step();
    flag_clr = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(flag == 1, "R7 start wins", flag, 1);
    end
    flag_clr = 0;
    irq_en = 0;
    stop(0);

    // R11 slow tick rate
    clr_flag();
    write_cmp(5, 2);
    write_ctl(1, 0, 1, 0);
    repeat (255) step();
    chk(flag == 0, "R11 before 256", flag, 0);
    step();
    chk(flag == 1, "R11 at 256", flag, 1);
    stop(0);

    summary();
  end
endmodule